// File: doc/BRIEF.md
# Completion Event Ring Writer

The block turns each finished transfer into a 16-byte completion record and stores it into a circular event ring in memory. A completion arrives on a valid/ready stream that carries a 4-bit status code and a 4-bit error detail. Each accepted completion becomes exactly one memory write, and records land in the ring in the order in which their completions were accepted. Because completions arrive in the order their descriptors were consumed, the ring order matches descriptor order.

Positions in the ring are byte offsets that step by 16 and wrap at a programmable ring length. The producer position is visible on a plain output. Software frees consumed entries by writing its read offset through a doorbell strobe. The ring is treated as full when the next producer position would land on the last accepted doorbell offset. While the ring is full the stream stalls: `cpl_ready` stays low and a held `cpl_valid` is simply not taken. A completion is accepted on a clock edge where both `cpl_valid` and `cpl_ready` are high. The sender must keep `cpl_code` and `cpl_info` stable while `cpl_valid` is high and `cpl_ready` is low. `ring_len` must be a multiple of 16, must be at least 32, and is held steady outside reset.

Every record written also sends a one-cycle end-of-block pulse toward the interrupt logic.

Top module: `evt_ring_writer`

## Requirements
- R1: After reset `wr_offset` is 0, the doorbell offset is 0, `cpl_ready` is 1, and `mem_we` and `eob_pulse` are 0.
- R2: For each accepted completion, `mem_we` is high for exactly one cycle, starting in the cycle after acceptance. `mem_addr` during that cycle equals the `wr_offset` value held at acceptance.
- R3: The record sits in `mem_wdata`. Bits 31:28 hold the status code (1 = completed, 4 = error) and bits 27:24 hold the error detail. All other bits of the 128-bit record are 0.
- R4: Each acceptance moves `wr_offset` forward by 16. When the sum would reach or pass `ring_len`, `wr_offset` returns to 0 instead. Without an acceptance, `wr_offset` holds its value.
- R5: `cpl_ready` is 0 exactly when the next producer offset equals the stored doorbell offset. While it is 0, a held `cpl_valid` causes no memory write and no change of `wr_offset`.
- R6: A `db_valid` strobe carrying a valid offset replaces the stored doorbell offset. `cpl_ready` reflects the new value from the following cycle.
- R7: A doorbell offset is ignored when it is not a multiple of 16 (bits 3:0 not zero) or when it is not below `ring_len`. The stored doorbell offset, and therefore `cpl_ready`, stays unchanged.
- R8: `eob_pulse` is high in exactly the cycles in which `mem_we` is high.
- R9: Records are written in the order their completions were accepted, with no record lost or duplicated.
- R10: `wr_offset` is always a multiple of 16 and is below `ring_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_len | input | OFS_W | Ring length in bytes, a multiple of 16 |
| cpl_valid | input | 1 | Completion present |
| cpl_ready | output | 1 | Ring has room; completion taken when both are high |
| cpl_code | input | 4 | Status code of the completion |
| cpl_info | input | 4 | Error detail of the completion |
| db_valid | input | 1 | Doorbell write strobe |
| db_offset | input | OFS_W | Software read offset in bytes |
| wr_offset | output | OFS_W | Current producer byte offset |
| mem_we | output | 1 | Memory write enable, one record per cycle |
| mem_addr | output | OFS_W | Byte offset of the record being written |
| mem_wdata | output | REC_W | Record contents |
| eob_pulse | output | 1 | One-cycle end-of-block event per record |

## Verification
The bench fills a 64-byte ring to its three-entry limit and holds a completion against the full ring. A design that compared the current offset instead of the next one would write a fourth record over unread data, and the scoreboard would catch the unexpected write. Misaligned and out-of-range doorbell offsets are sent while the ring is stalled. A design that accepted either one would raise `cpl_ready` early. Wrap is checked at 64 bytes and again after a fresh reset at a 48-byte length. A design that wrapped on a power-of-two mask, or that left the old doorbell offset in place across reset, would produce wrong addresses or a wrong full point.

// File: rtl/evt_ring_pkg.sv
package evt_ring_pkg;
  localparam int REC_BYTES = 16;
  localparam int REC_SHIFT = $clog2(REC_BYTES);

  typedef enum logic [3:0] {
    ST_DONE  = 4'd1,
    ST_ERROR = 4'd4
  } cpl_status_e;

  typedef struct packed {
    logic [3:0]  code;
    logic [3:0]  info;
    logic [23:0] rsvd;
  } rec_word0_t;
endpackage

// File: rtl/evt_ring_ptr.sv
module evt_ring_ptr
  import evt_ring_pkg::*;
#(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFS_W-1:0] ring_len,
  input  logic             adv,
  input  logic             db_valid,
  input  logic [OFS_W-1:0] db_offset,
  output logic [OFS_W-1:0] wr_off,
  output logic             room
);
  logic [OFS_W-1:0] rd_off;
  logic [OFS_W-1:0] nxt_off;
  logic [OFS_W:0]   sum;
  logic             db_ok;

  always_comb begin
    sum     = {1'b0, wr_off} + (OFS_W+1)'(REC_BYTES);
    nxt_off = (sum >= {1'b0, ring_len}) ? '0 : sum[OFS_W-1:0];
    room    = (nxt_off != rd_off);
    db_ok   = (db_offset[REC_SHIFT-1:0] == '0) && (db_offset < ring_len);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_off <= '0;
      rd_off <= '0;
    end else begin
      if (adv) wr_off <= nxt_off;
      if (db_valid && db_ok) rd_off <= db_offset;
    end
  end

  assert_align_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_off[REC_SHIFT-1:0] == '0) && (wr_off < ring_len));

  assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (wr_off == '0) || (wr_off == $past(wr_off) + OFS_W'(REC_BYTES)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(wr_off));

  assert_bad_db_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (db_valid && (db_offset[REC_SHIFT-1:0] != '0)) |=> $stable(rd_off));
endmodule

// File: rtl/evt_rec_fmt.sv
module evt_rec_fmt
  import evt_ring_pkg::*;
#(
  parameter int REC_W = 128
) (
  input  logic [3:0]       code,
  input  logic [3:0]       info,
  output logic [REC_W-1:0] rec
);
  rec_word0_t w0;

  always_comb begin
    w0.code   = code;
    w0.info   = info;
    w0.rsvd   = '0;
    rec       = '0;
    rec[31:0] = w0;
  end
endmodule

// File: rtl/evt_ring_writer.sv
module evt_ring_writer
  import evt_ring_pkg::*;
#(
  parameter int OFS_W = 16,
  parameter int REC_W = REC_BYTES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFS_W-1:0] ring_len,
  input  logic             cpl_valid,
  output logic             cpl_ready,
  input  logic [3:0]       cpl_code,
  input  logic [3:0]       cpl_info,
  input  logic             db_valid,
  input  logic [OFS_W-1:0] db_offset,
  output logic [OFS_W-1:0] wr_offset,
  output logic             mem_we,
  output logic [OFS_W-1:0] mem_addr,
  output logic [REC_W-1:0] mem_wdata,
  output logic             eob_pulse
);
  logic             take;
  logic [REC_W-1:0] rec;

  assign take = cpl_valid && cpl_ready;

  evt_ring_ptr #(.OFS_W(OFS_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ring_len (ring_len),
    .adv      (take),
    .db_valid (db_valid),
    .db_offset(db_offset),
    .wr_off   (wr_offset),
    .room     (cpl_ready)
  );

  evt_rec_fmt #(.REC_W(REC_W)) u_fmt (
    .code(cpl_code),
    .info(cpl_info),
    .rec (rec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      eob_pulse <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we    <= take;
      eob_pulse <= take;
      if (take) begin
        mem_addr  <= wr_offset;
        mem_wdata <= rec;
      end
    end
  end

  assert_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == $past(wr_offset)));

  assert_eob_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eob_pulse == mem_we);

  assert_no_write_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_ready) |=> !mem_we && $stable(wr_offset));

  assert_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata[31:24] == $past({cpl_code, cpl_info})) && (mem_wdata[23:0] == '0));
endmodule

// File: tb/evt_ring_writer_test.sv
module evt_ring_writer_test;
  localparam int OFS_W = 16;
  localparam int REC_W = 128;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n;
  logic [OFS_W-1:0] ring_len;
  logic             cpl_valid;
  logic             cpl_ready;
  logic [3:0]       cpl_code;
  logic [3:0]       cpl_info;
  logic             db_valid;
  logic [OFS_W-1:0] db_offset;
  logic [OFS_W-1:0] wr_offset;
  logic             mem_we;
  logic [OFS_W-1:0] mem_addr;
  logic [REC_W-1:0] mem_wdata;
  logic             eob_pulse;

  evt_ring_writer #(.OFS_W(OFS_W), .REC_W(REC_W)) uut (
    .clk(clk), .rst_n(rst_n), .ring_len(ring_len),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
    .cpl_code(cpl_code), .cpl_info(cpl_info),
    .db_valid(db_valid), .db_offset(db_offset),
    .wr_offset(wr_offset), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .eob_pulse(eob_pulse)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [OFS_W-1:0] a;
    logic [REC_W-1:0] d;
  } exp_t;
  exp_t q[$];
  logic [OFS_W-1:0] model_wr;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [REC_W-1:0] act, input logic [REC_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [REC_W-1:0] mkrec(input logic [3:0] c, input logic [3:0] i);
    logic [REC_W-1:0] r;
    r = '0;
    r[31:28] = c;
    r[27:24] = i;
    return r;
  endfunction

  task automatic expect_accept();
    exp_t e;
    e.a = model_wr;
    e.d = mkrec(cpl_code, cpl_info);
    q.push_back(e);
    model_wr = (model_wr + 16 >= ring_len) ? '0 : model_wr + 16;
  endtask

  task automatic send(input logic [3:0] c, input logic [3:0] i);
    @(negedge clk);
    cpl_valid = 1'b1;
    cpl_code  = c;
    cpl_info  = i;
    while (!cpl_ready) @(negedge clk);
    expect_accept();
    @(negedge clk);
    cpl_valid = 1'b0;
    chk(wr_offset == model_wr, "R4", "wr_offset after accept", wr_offset, model_wr);
  endtask

  task automatic doorbell(input logic [OFS_W-1:0] v);
    @(negedge clk);
    db_valid  = 1'b1;
    db_offset = v;
    @(negedge clk);
    db_valid  = 1'b0;
  endtask

  task automatic do_reset(input logic [OFS_W-1:0] len);
    @(negedge clk);
    rst_n = 1'b0;
    ring_len = len;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_wr = '0;
    chk(wr_offset == 0, "R1", "wr_offset at reset", wr_offset, 0);
    chk(cpl_ready == 1, "R1", "ready at reset", cpl_ready, 1);
    chk(mem_we == 0 && eob_pulse == 0, "R1", "no write at reset", {mem_we, eob_pulse}, 0);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(eob_pulse == mem_we, "R8", "eob vs mem_we", eob_pulse, mem_we);
      if (mem_we) begin
        if (q.size() == 0) begin
          chk(1'b0, "R9", "unexpected record", mem_addr, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(mem_addr == e.a, "R2", "record address", mem_addr, e.a);
          chk(mem_wdata == e.d, "R3", "record contents", mem_wdata, e.d);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ring_len = 16'd64; cpl_valid = 1'b0; cpl_code = '0;
    cpl_info = '0; db_valid = 1'b0; db_offset = '0; model_wr = '0;
    do_reset(16'd64);

    // Fill the 64-byte ring: three slots usable
    send(4'd1, 4'd0);
    send(4'd4, 4'd9);
    send(4'd1, 4'd3);
    chk(cpl_ready == 0, "R5", "full after three records", cpl_ready, 0);

    // Hold a completion against the full ring
    @(negedge clk);
    cpl_valid = 1'b1; cpl_code = 4'd1; cpl_info = 4'd5;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(cpl_ready == 0 && mem_we == 0, "R5", "stall while full", {cpl_ready, mem_we}, 0);
    end
    chk(wr_offset == 16'd48, "R5", "wr_offset held while full", wr_offset, 48);

    doorbell(16'd40);
    chk(cpl_ready == 0, "R7", "misaligned doorbell ignored", cpl_ready, 0);
    doorbell(16'd64);
    chk(cpl_ready == 0, "R7", "out-of-range doorbell ignored", cpl_ready, 0);
    doorbell(16'd32);
    chk(cpl_ready == 1, "R6", "doorbell frees room", cpl_ready, 1);
    expect_accept();
    @(negedge clk);
    cpl_valid = 1'b0;
    chk(wr_offset == 16'd0, "R4", "wrap to zero at 64", wr_offset, 0);

    send(4'd4, 4'd15);
    chk(cpl_ready == 0, "R5", "full against doorbell 32", cpl_ready, 0);
    doorbell(16'd16);
    chk(cpl_ready == 1, "R6", "doorbell 16 frees room", cpl_ready, 1);
    send(4'd1, 4'd1);
    send(4'd1, 4'd2);
    send(4'd4, 4'd7);
    chk(cpl_ready == 0, "R5", "full against doorbell 16", cpl_ready, 0);
    chk(wr_offset < ring_len && wr_offset[3:0] == 0, "R10", "offset aligned and in range", wr_offset, 0);

    // Fresh reset with a non-power-of-two length
    do_reset(16'd48);
    send(4'd1, 4'd4);
    send(4'd4, 4'd8);
    chk(cpl_ready == 0, "R5", "full in 48-byte ring (doorbell reset to 0)", cpl_ready, 0);
    doorbell(16'd16);
    send(4'd1, 4'd6);
    chk(wr_offset == 16'd0, "R4", "wrap to zero at 48", wr_offset, 0);

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R9", "all records written", q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule